// File: doc/BRIEF.md
# Tic-Tac-Toe Board Pixel Renderer

This block produces the colour of each pixel for a 640x480 picture of a noughts-and-crosses board. A timing generator elsewhere supplies the horizontal and vertical pixel counters and an active-video flag. A host supplies a 22-bit command word. The block turns these into 8-bit red, green and blue values, which go to a video DAC. It does not generate sync and does not drive the DAC itself.

The command word has two parts. A 4-bit display mode selects the picture: a blank screen, a screen filled with one winner's colour, a solid screen that flags an invalid entry, or the live board. A 2-bit state for each of the nine cells says what that cell shows when the live board is selected. The board has four white lines that split the screen into a 3x3 grid. A red cell holds a diagonal cross. A blue cell holds a ring. A green cell is filled solid as a cursor. A black cell stays empty.

The block takes a new command word only at the first pixel of a frame, so the picture never tears partway through a frame. Every colour decision uses plain per-pixel arithmetic on the counters. There is no frame store.

Top module: `boardRenderer`

## Requirements
- R1: The command word carries the mode in bits 21:18. Cell k (k = 1..9) is in bits 2k-1:2k-2, and the cells are numbered row by row from the top left. The column is 0 for x<213, 1 for 213<=x<427 and 2 otherwise. The row is 0 for y<160, 1 for 160<=y<320 and 2 otherwise. A cell state of 00 means empty (black), 01 red, 10 blue and 11 green.
- R2: The block latches the command word only on a clock edge where both counters are zero. The latched word governs every pixel from that pixel to the end of the frame. A change of the word at any other pixel has no effect on the picture.
- R3: When the active-video flag is low, the output is zero on all three channels, whatever the mode.
- R4: Mode 0000 gives an all-black picture. Any mode code not listed in R5, R6 or R7 also gives an all-black picture.
- R5: Mode 0001 fills the visible area with red (FF,00,00). Mode 0010 fills it with blue (00,00,FF).
- R6: Mode 0011, the invalid-entry screen, fills the visible area with green (00,FF,00).
- R7: Mode 1111 draws the board. A pixel is white (FF,FF,FF) when |y-160|<=8, |y-320|<=8, |x-213|<=8 or |x-427|<=8. Grid lines take priority over any cell content.
- R8: For a red cell, take dx and dy as the pixel's offset from the cell centre. The centre columns are 100, 320 and 540, and the centre rows are 73, 240 and 407. The pixel is red when |dx|<60, |dy|<60, and either |dx-dy|<12 or |dx+dy|<12. Otherwise the pixel is black.
- R9: For a blue cell, a pixel is blue when 2025 < dx²+dy² < 3600. Otherwise the pixel is black.
- R10: A green cell shows green on every pixel that is not a grid pixel. An empty cell shows black.
- R11: The output is registered. The colour for the inputs sampled on one clock edge appears after that edge. During reset the output is zero and the latched word is all zeros, which selects the blank mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hCount | input | 10 | Current horizontal pixel position |
| vCount | input | 10 | Current vertical pixel position |
| videoOn | input | 1 | High during the visible part of the frame |
| cmdWord | input | 22 | Mode and cell-state word from the host |
| red | output | 8 | Red channel level |
| green | output | 8 | Green channel level |
| blue | output | 8 | Blue channel level |

## Verification
Every colour is due on the first clock edge after the bench presents a pixel position. The bench changes its inputs on the falling edge, waits for one rising edge, and reads the output on the next falling edge. A new command word counts only after the bench has presented pixel (0,0) with that word for one edge. The mid-frame tests change the word at a non-zero position and then check that a later pixel still shows the earlier picture. Cross, ring and grid-line edges are each tested on both sides of the boundary, one pixel apart.

// File: rtl/boardPkg.sv
package boardPkg;
  localparam int CMD_W    = 22;
  localparam int MODE_W   = 4;
  localparam int CELL_W   = 2;
  localparam int N_CELLS  = 9;
  localparam int CELLS_W  = CELL_W * N_CELLS;

  typedef enum logic [MODE_W-1:0] {
    MODE_BLANK = 4'b0000,
    MODE_XWIN  = 4'b0001,
    MODE_OWIN  = 4'b0010,
    MODE_BAD   = 4'b0011,
    MODE_BOARD = 4'b1111
  } mode_e;

  typedef enum logic [CELL_W-1:0] {
    CELL_EMPTY = 2'b00,
    CELL_RED   = 2'b01,
    CELL_BLUE  = 2'b10,
    CELL_GREEN = 2'b11
  } cell_e;

  // strobes from control to datapath, at most one fill/draw active
  typedef struct packed {
    logic               drawBoard;
    logic               fillRed;
    logic               fillBlue;
    logic               fillGreen;
    logic [CELLS_W-1:0] cells;
  } ctrl_t;
endpackage

// File: rtl/boardCtrl.sv
module boardCtrl
  import boardPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] hCount,
  input  logic [CNT_W-1:0] vCount,
  input  logic [CMD_W-1:0] cmdWord,
  output ctrl_t            ctrl
);
  logic [CMD_W-1:0] cmdReg;
  logic [CMD_W-1:0] effWord;
  logic             frameStart;
  mode_e            mode;

  assign frameStart = (hCount == '0) && (vCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) cmdReg <= '0;
    else if (frameStart) cmdReg <= cmdWord;
  end

  // the word present at the first pixel already governs that pixel
  assign effWord = frameStart ? cmdWord : cmdReg;
  assign mode    = mode_e'(effWord[CMD_W-1 -: MODE_W]);

  always_comb begin
    ctrl           = '0;
    ctrl.cells     = effWord[CELLS_W-1:0];
    unique case (mode)
      MODE_BOARD: ctrl.drawBoard = 1'b1;
      MODE_XWIN:  ctrl.fillRed   = 1'b1;
      MODE_OWIN:  ctrl.fillBlue  = 1'b1;
      MODE_BAD:   ctrl.fillGreen = 1'b1;
      default:    ;
    endcase
  end

  // R2
  capture_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (cmdReg == $past(cmdWord)));

  // R2
  hold_mid_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !$past(frameStart)) |=> $stable(cmdReg));

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.drawBoard, ctrl.fillRed, ctrl.fillBlue, ctrl.fillGreen}));
endmodule

// File: rtl/boardPath.sv
module boardPath
  import boardPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int COLOR_W  = 8,
  parameter int ROW_EDGE0 = 160,
  parameter int ROW_EDGE1 = 320,
  parameter int COL_EDGE0 = 213,
  parameter int COL_EDGE1 = 427,
  parameter int LINE_HALF = 8,
  parameter int CX0 = 100, parameter int CX1 = 320, parameter int CX2 = 540,
  parameter int CY0 = 73,  parameter int CY1 = 240, parameter int CY2 = 407,
  parameter int BAND_HALF = 12,
  parameter int MARK_TRIM = 60,
  parameter int RING_OUT  = 60,
  parameter int RING_IN   = 45
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   hCount,
  input  logic [CNT_W-1:0]   vCount,
  input  logic               videoOn,
  input  ctrl_t              ctrl,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);
  localparam logic [COLOR_W-1:0] FULL = {COLOR_W{1'b1}};
  localparam int RING_OUT_SQ = RING_OUT * RING_OUT;
  localparam int RING_IN_SQ  = RING_IN * RING_IN;
  localparam int N_LINES = 2;
  localparam int ROW_EDGES [N_LINES] = '{ROW_EDGE0, ROW_EDGE1};
  localparam int COL_EDGES [N_LINES] = '{COL_EDGE0, COL_EDGE1};

  function automatic int absI(input int a);
    return (a < 0) ? -a : a;
  endfunction

  logic [N_LINES-1:0] rowHit, colHit;
  logic               onGrid;

  for (genvar g = 0; g < N_LINES; g++) begin : gLines
    assign rowHit[g] = absI(int'(vCount) - ROW_EDGES[g]) <= LINE_HALF;
    assign colHit[g] = absI(int'(hCount) - COL_EDGES[g]) <= LINE_HALF;
  end
  assign onGrid = |{rowHit, colHit};

  logic [1:0] colIdx, rowIdx;
  int         cx, cy, dx, dy, dist2;
  cell_e      cellState;
  logic       inCross, inRing;

  always_comb begin
    colIdx = (int'(hCount) < COL_EDGE0) ? 2'd0 : (int'(hCount) < COL_EDGE1) ? 2'd1 : 2'd2;
    rowIdx = (int'(vCount) < ROW_EDGE0) ? 2'd0 : (int'(vCount) < ROW_EDGE1) ? 2'd1 : 2'd2;
    case (colIdx)
      2'd0:    cx = CX0;
      2'd1:    cx = CX1;
      default: cx = CX2;
    endcase
    case (rowIdx)
      2'd0:    cy = CY0;
      2'd1:    cy = CY1;
      default: cy = CY2;
    endcase
    dx    = int'(hCount) - cx;
    dy    = int'(vCount) - cy;
    dist2 = dx * dx + dy * dy;
    cellState = cell_e'(ctrl.cells[(int'(rowIdx) * 3 + int'(colIdx)) * CELL_W +: CELL_W]);
    inCross = (absI(dx) < MARK_TRIM) && (absI(dy) < MARK_TRIM) &&
              ((absI(dx - dy) < BAND_HALF) || (absI(dx + dy) < BAND_HALF));
    inRing  = (dist2 > RING_IN_SQ) && (dist2 < RING_OUT_SQ);
  end

  logic [COLOR_W-1:0] rNext, gNext, bNext;

  always_comb begin
    {rNext, gNext, bNext} = '0;
    if (videoOn) begin
      if (ctrl.fillRed)        rNext = FULL;
      else if (ctrl.fillBlue)  bNext = FULL;
      else if (ctrl.fillGreen) gNext = FULL;
      else if (ctrl.drawBoard) begin
        if (onGrid) {rNext, gNext, bNext} = {3{FULL}};
        else begin
          unique case (cellState)
            CELL_RED:   if (inCross) rNext = FULL;
            CELL_BLUE:  if (inRing)  bNext = FULL;
            CELL_GREEN: gNext = FULL;
            default:    ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      red <= '0; green <= '0; blue <= '0;
    end else begin
      red <= rNext; green <= gNext; blue <= bNext;
    end
  end

  // R3
  dark_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !videoOn |=> (red == '0 && green == '0 && blue == '0));

  // R5
  red_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    (videoOn && ctrl.fillRed) |=> (red == FULL && green == '0 && blue == '0));

  // R6
  green_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (videoOn && ctrl.fillGreen) |=> (red == '0 && green == FULL && blue == '0));

  // R4
  blank_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.drawBoard || ctrl.fillRed || ctrl.fillBlue || ctrl.fillGreen)
      |=> (red == '0 && green == '0 && blue == '0));

  // R7
  palette_chk: assert property (@(posedge clk) disable iff (!rstN)
    (red == '0 || red == FULL) && (green == '0 || green == FULL) &&
    (blue == '0 || blue == FULL));
endmodule

// File: rtl/boardRenderer.sv
module boardRenderer
  import boardPkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   hCount,
  input  logic [CNT_W-1:0]   vCount,
  input  logic               videoOn,
  input  logic [21:0]        cmdWord,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);
  ctrl_t ctrl;

  boardCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .cmdWord(cmdWord), .ctrl(ctrl)
  );

  boardPath #(.CNT_W(CNT_W), .COLOR_W(COLOR_W)) uPath (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .videoOn(videoOn), .ctrl(ctrl), .red(red), .green(green), .blue(blue)
  );
endmodule

// File: tb/sim_boardRenderer.sv
module sim_boardRenderer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  hCount = '0;
  logic [9:0]  vCount = '0;
  logic        videoOn = 1'b0;
  logic [21:0] cmdWord = '0;
  logic [7:0]  red, green, blue;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [23:0] BLACK = 24'h000000;
  localparam logic [23:0] RED   = 24'hFF0000;
  localparam logic [23:0] GREEN = 24'h00FF00;
  localparam logic [23:0] BLUE  = 24'h0000FF;
  localparam logic [23:0] WHITE = 24'hFFFFFF;

  always #5 clk = ~clk;

  boardRenderer u0 (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .videoOn(videoOn), .cmdWord(cmdWord), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [21:0] mkWord(input logic [3:0] mode,
                                         input logic [17:0] cells);
    return {mode, cells};
  endfunction

  // cell k (1..9) placed at bits 2k-1:2k-2
  function automatic logic [17:0] cellAt(input int k, input logic [1:0] st);
    logic [17:0] v;
    v = '0;
    v[2*(k-1) +: 2] = st;
    return v;
  endfunction

  task automatic compare(input string tag, input logic [23:0] expv);
    checks++;
    if ({red, green, blue} !== expv) begin
      failures++;
      $display("FAIL %s: actual=%06h expected=%06h", tag, {red, green, blue}, expv);
    end
  endtask

  // present one pixel, output is due after the next rising edge
  task automatic pix(input int h, input int v, input bit vid,
                     input logic [23:0] expv, input string tag);
    @(negedge clk);
    hCount  = 10'(h);
    vCount  = 10'(v);
    videoOn = vid;
    @(negedge clk);
    compare(tag, expv);
  endtask

  task automatic loadWord(input logic [21:0] w);
    @(negedge clk);
    cmdWord = w;
    hCount = '0; vCount = '0; videoOn = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    // R11 output zero during reset
    compare("R11 reset output", BLACK);
    rstN = 1'b1;
    // R11 latched word resets to blank
    pix(300, 200, 1'b1, BLACK, "R11 blank after reset");
  endtask

  task automatic testFills();
    loadWord(mkWord(4'b0000, 18'h3FFFF));
    pix(100, 73, 1'b1, BLACK, "R4 blank mode");
    loadWord(mkWord(4'b0101, '0));
    pix(320, 240, 1'b1, BLACK, "R4 unlisted mode");
    loadWord(mkWord(4'b0001, '0));
    pix(5, 5, 1'b1, RED, "R5 red win");
    pix(5, 5, 1'b0, BLACK, "R3 inactive in red win");
    loadWord(mkWord(4'b0010, '0));
    pix(639, 479, 1'b1, BLUE, "R5 blue win");
    loadWord(mkWord(4'b0011, '0));
    pix(400, 100, 1'b1, GREEN, "R6 invalid screen");
  endtask

  task automatic testGrid();
    loadWord(mkWord(4'b1111, '0));
    pix(205, 50, 1'b1, WHITE, "R7 column line low edge");
    pix(204, 50, 1'b1, BLACK, "R7 just left of line");
    pix(221, 50, 1'b1, WHITE, "R7 column line high edge");
    pix(222, 50, 1'b1, BLACK, "R7 just right of line");
    pix(30, 152, 1'b1, WHITE, "R7 row line edge");
    pix(30, 151, 1'b1, BLACK, "R7 above row line");
    pix(427, 328, 1'b1, WHITE, "R7 second lines");
    pix(427, 328, 1'b0, BLACK, "R3 grid inactive");
  endtask

  task automatic testCross();
    loadWord(mkWord(4'b1111, cellAt(1, 2'b01)));
    pix(100, 73, 1'b1, RED, "R8 cross centre");
    pix(111, 73, 1'b1, RED, "R8 band edge inside");
    pix(112, 73, 1'b1, BLACK, "R8 band edge outside");
    pix(159, 132, 1'b1, RED, "R8 trim inside");
    pix(160, 133, 1'b1, BLACK, "R8 trim outside");
    pix(41, 132, 1'b1, RED, "R8 second diagonal");
    // R1 cell 3 sits at bits 5:4, top right
    loadWord(mkWord(4'b1111, cellAt(3, 2'b01)));
    pix(540, 73, 1'b1, RED, "R1 cell 3 position");
    pix(100, 73, 1'b1, BLACK, "R1 cell 1 empty");
  endtask

  task automatic testRing();
    loadWord(mkWord(4'b1111, cellAt(5, 2'b10)));
    pix(370, 240, 1'b1, BLUE, "R9 ring middle");
    pix(365, 240, 1'b1, BLACK, "R9 inner radius excluded");
    pix(379, 240, 1'b1, BLUE, "R9 near outer radius");
    pix(380, 240, 1'b1, BLACK, "R9 outer radius excluded");
    pix(320, 240, 1'b1, BLACK, "R9 ring centre empty");
  endtask

  task automatic testGreen();
    loadWord(mkWord(4'b1111, cellAt(9, 2'b11) | cellAt(7, 2'b01)));
    pix(600, 450, 1'b1, GREEN, "R10 green cell fill");
    pix(440, 340, 1'b1, GREEN, "R10 green cell corner");
    pix(430, 450, 1'b1, WHITE, "R7 grid over green");
    pix(300, 400, 1'b1, BLACK, "R10 empty cell");
    pix(100, 407, 1'b1, RED, "R1 cell 7 bottom left");
  endtask

  task automatic testCapture();
    loadWord(mkWord(4'b0001, '0));
    pix(10, 10, 1'b1, RED, "R2 word loaded");
    @(negedge clk);
    cmdWord = mkWord(4'b0010, '0);
    pix(200, 300, 1'b1, RED, "R2 mid-frame change ignored");
    pix(0, 1, 1'b1, RED, "R2 line start ignored");
    pix(0, 0, 1'b1, BLUE, "R2 frame start takes word");
    pix(50, 50, 1'b1, BLUE, "R2 new word holds");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFills();
    testGrid();
    testCross();
    testRing();
    testGreen();
    testCapture();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule